// File: doc/BRIEF.md
# Peripheral Bus Request Packet Formatter

This block sits behind a host command decoder and turns one command packet into a transaction request for a serial peripheral bus. A packet arrives all at once as a byte count and a flat vector of argument bytes. The block classifies the packet and then takes one of these actions:

- it discards the packet;
- it reprograms the bus autopoll controls;
- it stores an error reply;
- it raises a formatted request towards the bus port and holds it until the bus answers.

The block turns the bus answer into a framed reply record that starts with a status byte. It keeps that record until the host picks it up, and it raises a reply interrupt whenever a record is written.

A second packet kind, the poll-off command, carries no arguments and switches autopolling off. While a bus request is outstanding, the block refuses new packets and asserts a hold output so that the autopoll engine stays quiet.

Top module: `pbf_top`

## Requirements
- R1: A bus packet with a count below 2, or above MAX_ARGS, changes nothing: no request, no reply, no interrupt and no autopoll change.
- R2: While `bus_present` is low, bus packets and poll-off commands are accepted but have no effect on any output.
- R3: A bus packet whose byte 0 is 0x00 and byte 1 is 0x86 is the autopoll form. It acts only when the count is exactly 4, and its mask is byte 2 (high) concatenated with byte 3 (low). With any other count it does nothing.
- R4: An autopoll form with a nonzero mask loads `ap_mask` and sets `ap_enable`. A zero mask clears `ap_enable` and leaves `ap_mask` unchanged.
- R5: For other bus packets, byte 2 is the declared length. If it exceeds count minus 3, or exceeds 252, no request is made, and a one-byte reply 0x00 is stored with the interrupt set. A count of 2 therefore always takes this path.
- R6: A valid bus packet raises `breq_valid` from the cycle after acceptance until the cycle after `bus_rsp_valid`.
  - `breq_len` is count minus 2.
  - `breq_bytes` byte 0 is packet byte 0, and byte i for i≥1 is packet byte i+2.
  - Request bytes at positions of `breq_len` and above read zero, and all request outputs are zero when idle.
- R7: A bus response of N bytes with 1 ≤ N ≤ MAX_RSP is stored as 0x01, N, then the data, with `rep_size` N+2. N of 0, or N above MAX_RSP, is stored as the single byte 0x00 with `rep_size` 1. Unused reply bytes read zero.
- R8: Every stored reply sets `rep_int`. `rep_ack` clears `rep_int`, `rep_size` and the reply bytes, unless a reply is written in the same cycle, in which case the new reply wins and `rep_int` stays high.
- R9: A poll-off command (`pkt_kind` = 1) with count 0 clears `ap_enable`. With a nonzero count it does nothing.
- R10: `pkt_ready` is low and `ap_hold` is high while a request is outstanding. Packets offered then are ignored.
- R11: After reset `ap_enable`, `ap_mask`, `rep_int`, `rep_size` and `breq_valid` are 0 and `pkt_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_present | input | 1 | Configuration: peripheral bus fitted |
| pkt_valid | input | 1 | Packet offered this cycle |
| pkt_kind | input | 1 | 0 = bus packet, 1 = poll-off command |
| pkt_count | input | $clog2(MAX_ARGS+1) (5) | Number of argument bytes |
| pkt_bytes | input | MAX_ARGS*8 (128) | Argument bytes, byte i at bits 8i+7:8i |
| pkt_ready | output | 1 | Block idle, packet accepted when valid |
| breq_valid | output | 1 | Bus request outstanding |
| breq_len | output | $clog2(MAX_ARGS+1) (5) | Request length in bytes |
| breq_bytes | output | (MAX_ARGS-2)*8 (112) | Request bytes, byte i at bits 8i+7:8i |
| bus_rsp_valid | input | 1 | Bus answer present this cycle |
| bus_rsp_len | input | $clog2(MAX_RSP+1) (4) | Bytes returned by the bus, 0 = failure |
| bus_rsp_bytes | input | MAX_RSP*8 (64) | Returned bytes |
| ap_enable | output | 1 | Autopoll enabled |
| ap_mask | output | 16 | Autopoll device mask |
| ap_hold | output | 1 | Autopoll held off while busy |
| rep_ack | input | 1 | Host picks up the stored reply |
| rep_int | output | 1 | Reply interrupt bit |
| rep_size | output | $clog2(MAX_RSP+3) (4) | Stored reply size in bytes |
| rep_bytes | output | (MAX_RSP+2)*8 (80) | Stored reply, byte i at bits 8i+7:8i |

## Verification
Two events can meet in one cycle: the host's pickup acknowledge and a reply write. The write can come from a bus response or from a packet that fails the length check at acceptance. The bench provokes both cases by holding `rep_ack` high in the very cycle of `bus_rsp_valid`, and again in the cycle an erroneous packet is accepted. It expects the fresh reply to remain stored with `rep_int` high. A reference model in the bench applies the same write-before-clear rule and is compared with every output on every clock, over directed and randomised traffic that mixes acknowledges with responses.

// File: rtl/pbf_pkg.sv
package pbf_pkg;

   // Action chosen for an accepted packet
   typedef enum logic [2:0] {
      ACT_NONE    = 3'd0,
      ACT_AP_LOAD = 3'd1,
      ACT_AP_OFF  = 3'd2,
      ACT_ERR     = 3'd3,
      ACT_BUS     = 3'd4
   } pbf_act_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } pbf_state_e;

   localparam int AP_MASK_W = 16;
   localparam int AP_COUNT  = 4;

endpackage

// File: rtl/pbf_classify.sv
module pbf_classify
   import pbf_pkg::*;
#(
   parameter int          MAX_ARGS = 16,
   parameter logic [7:0]  PFX0     = 8'h00,
   parameter logic [7:0]  PFX1     = 8'h86,
   parameter int          DECL_MAX = 252,
   localparam int         CW       = $clog2(MAX_ARGS + 1),
   localparam int         RQ       = MAX_ARGS - 2
)(
   input  logic                   kind_i,
   input  logic                   bus_present_i,
   input  logic [CW-1:0]          count_i,
   input  logic [MAX_ARGS*8-1:0]  bytes_i,
   output pbf_act_e               act_o,
   output logic [AP_MASK_W-1:0]   mask_o,
   output logic [CW-1:0]          req_len_o,
   output logic [RQ*8-1:0]        req_bytes_o
);

   logic [7:0] b0, b1, b2, b3;
   logic [8:0] count_ext;
   logic [8:0] decl_plus3;
   logic       len_ok;
   logic       is_pfx;
   logic       decl_bad;

   assign b0 = bytes_i[7:0];
   assign b1 = bytes_i[15:8];
   assign b2 = bytes_i[23:16];
   assign b3 = bytes_i[31:24];

   assign count_ext  = 9'(count_i);
   assign decl_plus3 = {1'b0, b2} + 9'd3;
   assign len_ok     = (count_ext >= 9'd2) && (count_ext <= 9'(MAX_ARGS));
   assign is_pfx     = (b0 == PFX0) && (b1 == PFX1);
   assign decl_bad   = (decl_plus3 > count_ext) || ({1'b0, b2} > 9'(DECL_MAX));
   assign mask_o     = {b2, b3};
   assign req_len_o  = count_i - CW'(2);

   always_comb begin
      act_o = ACT_NONE;
      if (kind_i) begin
         if (bus_present_i && (count_i == '0)) begin
            act_o = ACT_AP_OFF;
         end
      end else if (len_ok && bus_present_i) begin
         if (is_pfx) begin
            if (count_ext == 9'(AP_COUNT)) begin
               act_o = (mask_o != '0) ? ACT_AP_LOAD : ACT_AP_OFF;
            end
         end else if (decl_bad) begin
            act_o = ACT_ERR;
         end else begin
            act_o = ACT_BUS;
         end
      end
   end

   // Request byte 0 is the address byte, the rest skip the length field
   for (genvar i = 0; i < RQ; i++) begin : g_req
      localparam int SRC = (i == 0) ? 0 : i + 2;
      assign req_bytes_o[8*i +: 8] =
         (9'(i) < 9'(req_len_o)) ? bytes_i[8*SRC +: 8] : 8'h00;
   end

endmodule

// File: rtl/pbf_autopoll_ctl.sv
module pbf_autopoll_ctl
   import pbf_pkg::*;
#(
   parameter logic [AP_MASK_W-1:0] RESET_MASK = '0
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  apply_i,
   input  pbf_act_e              act_i,
   input  logic [AP_MASK_W-1:0]  mask_i,
   output logic                  en_o,
   output logic [AP_MASK_W-1:0]  mask_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         mask_o <= RESET_MASK;
      end else if (apply_i) begin
         case (act_i)
            ACT_AP_LOAD: begin
               en_o   <= 1'b1;
               mask_o <= mask_i;
            end
            ACT_AP_OFF: en_o <= 1'b0;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pbf_reply_store.sv
module pbf_reply_store #(
   parameter int  MAX_RSP = 8,
   localparam int RW      = $clog2(MAX_RSP + 1),
   localparam int SW      = $clog2(MAX_RSP + 3),
   localparam int NB      = MAX_RSP + 2
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  err_wr_i,
   input  logic                  rsp_wr_i,
   input  logic [RW-1:0]         rsp_len_i,
   input  logic [MAX_RSP*8-1:0]  rsp_bytes_i,
   input  logic                  ack_i,
   output logic                  int_o,
   output logic [SW-1:0]         size_o,
   output logic [NB*8-1:0]       bytes_o
);

   logic            wr;
   logic            ok;
   logic [SW-1:0]   nxt_size;
   logic [NB*8-1:0] nxt;

   assign wr = err_wr_i | rsp_wr_i;
   assign ok = rsp_wr_i && (rsp_len_i != '0) && (int'(rsp_len_i) <= MAX_RSP);

   assign nxt[7:0]  = ok ? 8'h01 : 8'h00;
   assign nxt[15:8] = ok ? 8'(rsp_len_i) : 8'h00;
   assign nxt_size  = ok ? (SW'(rsp_len_i) + SW'(2)) : SW'(1);

   for (genvar k = 0; k < MAX_RSP; k++) begin : g_pay
      assign nxt[8*(k+2) +: 8] =
         (ok && (int'(rsp_len_i) > k)) ? rsp_bytes_i[8*k +: 8] : 8'h00;
   end

   // A write in the same cycle as a pickup keeps the new record
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_o   <= 1'b0;
         size_o  <= '0;
         bytes_o <= '0;
      end else if (wr) begin
         int_o   <= 1'b1;
         size_o  <= nxt_size;
         bytes_o <= nxt;
      end else if (ack_i) begin
         int_o   <= 1'b0;
         size_o  <= '0;
         bytes_o <= '0;
      end
   end

endmodule

// File: rtl/pbf_top.sv
module pbf_top
   import pbf_pkg::*;
#(
   parameter int          MAX_ARGS   = 16,
   parameter int          MAX_RSP    = 8,
   parameter logic [7:0]  AP_PREFIX0 = 8'h00,
   parameter logic [7:0]  AP_PREFIX1 = 8'h86,
   parameter int          DECL_MAX   = 252,
   localparam int         CW         = $clog2(MAX_ARGS + 1),
   localparam int         RW         = $clog2(MAX_RSP + 1),
   localparam int         SW         = $clog2(MAX_RSP + 3),
   localparam int         RQ         = MAX_ARGS - 2,
   localparam int         NB         = MAX_RSP + 2
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_present,
   input  logic                  pkt_valid,
   input  logic                  pkt_kind,
   input  logic [CW-1:0]         pkt_count,
   input  logic [MAX_ARGS*8-1:0] pkt_bytes,
   output logic                  pkt_ready,
   output logic                  breq_valid,
   output logic [CW-1:0]         breq_len,
   output logic [RQ*8-1:0]       breq_bytes,
   input  logic                  bus_rsp_valid,
   input  logic [RW-1:0]         bus_rsp_len,
   input  logic [MAX_RSP*8-1:0]  bus_rsp_bytes,
   output logic                  ap_enable,
   output logic [15:0]           ap_mask,
   output logic                  ap_hold,
   input  logic                  rep_ack,
   output logic                  rep_int,
   output logic [SW-1:0]         rep_size,
   output logic [NB*8-1:0]       rep_bytes
);

   // Elaboration-time parameter checks
   if (MAX_ARGS < AP_COUNT || MAX_ARGS > 255) begin : g_bad_args
      $error("pbf_top: MAX_ARGS must lie in 4..255");
   end
   if (MAX_RSP < 1 || MAX_RSP > 253) begin : g_bad_rsp
      $error("pbf_top: MAX_RSP must lie in 1..253");
   end
   if (DECL_MAX < 0 || DECL_MAX > 255) begin : g_bad_decl
      $error("pbf_top: DECL_MAX must lie in 0..255");
   end

   pbf_state_e             st;
   pbf_act_e               act;
   logic [AP_MASK_W-1:0]   cls_mask;
   logic [CW-1:0]          cls_len;
   logic [RQ*8-1:0]        cls_bytes;
   logic                   accept;
   logic                   rsp_take;
   logic [CW-1:0]          req_len_q;
   logic [RQ*8-1:0]        req_bytes_q;

   assign accept   = pkt_valid && (st == ST_IDLE);
   assign rsp_take = bus_rsp_valid && (st == ST_WAIT);

   pbf_classify #(
      .MAX_ARGS (MAX_ARGS),
      .PFX0     (AP_PREFIX0),
      .PFX1     (AP_PREFIX1),
      .DECL_MAX (DECL_MAX)
   ) u_classify (
      .kind_i        (pkt_kind),
      .bus_present_i (bus_present),
      .count_i       (pkt_count),
      .bytes_i       (pkt_bytes),
      .act_o         (act),
      .mask_o        (cls_mask),
      .req_len_o     (cls_len),
      .req_bytes_o   (cls_bytes)
   );

   pbf_autopoll_ctl #(
      .RESET_MASK ('0)
   ) u_autopoll (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply_i (accept),
      .act_i   (act),
      .mask_i  (cls_mask),
      .en_o    (ap_enable),
      .mask_o  (ap_mask)
   );

   pbf_reply_store #(
      .MAX_RSP (MAX_RSP)
   ) u_reply (
      .clk         (clk),
      .rst_n       (rst_n),
      .err_wr_i    (accept && (act == ACT_ERR)),
      .rsp_wr_i    (rsp_take),
      .rsp_len_i   (bus_rsp_len),
      .rsp_bytes_i (bus_rsp_bytes),
      .ack_i       (rep_ack),
      .int_o       (rep_int),
      .size_o      (rep_size),
      .bytes_o     (rep_bytes)
   );

   // Request holding register and busy state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         req_len_q   <= '0;
         req_bytes_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept && (act == ACT_BUS)) begin
                  st          <= ST_WAIT;
                  req_len_q   <= cls_len;
                  req_bytes_q <= cls_bytes;
               end
            end
            ST_WAIT: begin
               if (bus_rsp_valid) begin
                  st          <= ST_IDLE;
                  req_len_q   <= '0;
                  req_bytes_q <= '0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign pkt_ready  = (st == ST_IDLE);
   assign breq_valid = (st == ST_WAIT);
   assign ap_hold    = (st == ST_WAIT);
   assign breq_len   = req_len_q;
   assign breq_bytes = req_bytes_q;

endmodule

// File: rtl/pbf_chk.sv
module pbf_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pkt_valid,
   input logic        pkt_ready,
   input logic        pkt_kind,
   input logic        short_pkt,
   input logic        bus_present,
   input logic        breq_valid,
   input logic        bus_rsp_valid,
   input logic        ap_enable,
   input logic [15:0] ap_mask,
   input logic        ap_hold,
   input logic        rep_ack,
   input logic        rep_int,
   input logic        rep_empty,
   input logic [7:0]  rep_head
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      breq_valid && !bus_rsp_valid |=> breq_valid); // R6

   AST_RSP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      breq_valid && bus_rsp_valid |=> !breq_valid && rep_int && !rep_empty); // R8

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rep_ack && !(breq_valid && bus_rsp_valid) && !(pkt_valid && pkt_ready)
      |=> !rep_int && rep_empty); // R8

   AST_SHORT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && pkt_ready && !pkt_kind && short_pkt
      |=> !breq_valid && $stable(ap_enable) && $stable(ap_mask)); // R1

   AST_ABSENT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && pkt_ready && !bus_present
      |=> !breq_valid && $stable(ap_enable) && $stable(ap_mask)); // R2

   AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      !rep_empty |-> rep_head <= 8'h01); // R7

   AST_INT_HAS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rep_int) |-> !rep_empty); // R8

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && pkt_ready && breq_valid |-> 1'b0); // R10

   AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ap_hold && !bus_rsp_valid |=> ap_hold); // R10

endmodule

bind pbf_top pbf_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pkt_valid     (pkt_valid),
   .pkt_ready     (pkt_ready),
   .pkt_kind      (pkt_kind),
   .short_pkt     (pkt_count < 2),
   .bus_present   (bus_present),
   .breq_valid    (breq_valid),
   .bus_rsp_valid (bus_rsp_valid),
   .ap_enable     (ap_enable),
   .ap_mask       (ap_mask),
   .ap_hold       (ap_hold),
   .rep_ack       (rep_ack),
   .rep_int       (rep_int),
   .rep_empty     (rep_size == '0),
   .rep_head      (rep_bytes[7:0])
);

// File: tb/tb_pbf_top.sv
module tb_pbf_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_ARGS   = 16;
   localparam int MAX_RSP    = 8;
   localparam int WATCHDOG   = 150000;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         bus_present;
   logic         pkt_valid;
   logic         pkt_kind;
   logic [4:0]   pkt_count;
   logic [127:0] pkt_bytes;
   logic         pkt_ready;
   logic         breq_valid;
   logic [4:0]   breq_len;
   logic [111:0] breq_bytes;
   logic         bus_rsp_valid;
   logic [3:0]   bus_rsp_len;
   logic [63:0]  bus_rsp_bytes;
   logic         ap_enable;
   logic [15:0]  ap_mask;
   logic         ap_hold;
   logic         rep_ack;
   logic         rep_int;
   logic [3:0]   rep_size;
   logic [79:0]  rep_bytes;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbf_top dut (
      .clk(clk), .rst_n(rst_n), .bus_present(bus_present),
      .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .pkt_count(pkt_count),
      .pkt_bytes(pkt_bytes), .pkt_ready(pkt_ready),
      .breq_valid(breq_valid), .breq_len(breq_len), .breq_bytes(breq_bytes),
      .bus_rsp_valid(bus_rsp_valid), .bus_rsp_len(bus_rsp_len),
      .bus_rsp_bytes(bus_rsp_bytes), .ap_enable(ap_enable), .ap_mask(ap_mask),
      .ap_hold(ap_hold), .rep_ack(rep_ack), .rep_int(rep_int),
      .rep_size(rep_size), .rep_bytes(rep_bytes)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit        m_busy;
   bit        m_en;
   bit [15:0] m_mask;
   bit        m_int;
   int        m_rsize;
   bit [7:0]  m_rep [10];
   int        m_qlen;
   bit [7:0]  m_req [14];

   always @(posedge clk) begin
      bit wr;
      int n;
      bit [7:0] b0, b1, b2, b3;
      if (!rst_n) begin
         m_busy = 0; m_en = 0; m_mask = 0; m_int = 0; m_rsize = 0; m_qlen = 0;
         foreach (m_rep[k]) m_rep[k] = 0;
         foreach (m_req[k]) m_req[k] = 0;
      end else begin
         wr = 0;
         if (m_busy && bus_rsp_valid) begin
            n = int'(bus_rsp_len);
            foreach (m_rep[k]) m_rep[k] = 0;
            if (n >= 1 && n <= MAX_RSP) begin
               m_rep[0] = 8'h01;
               m_rep[1] = 8'(n);
               for (int k = 0; k < n; k++) m_rep[k+2] = bus_rsp_bytes[8*k +: 8];
               m_rsize = n + 2;
            end else begin
               m_rsize = 1;
            end
            m_int = 1; wr = 1; m_busy = 0; m_qlen = 0;
            foreach (m_req[k]) m_req[k] = 0;
         end else if (!m_busy && pkt_valid) begin
            n  = int'(pkt_count);
            b0 = pkt_bytes[7:0];   b1 = pkt_bytes[15:8];
            b2 = pkt_bytes[23:16]; b3 = pkt_bytes[31:24];
            if (pkt_kind) begin
               if (bus_present && n == 0) m_en = 0;
            end else if (n >= 2 && n <= MAX_ARGS && bus_present) begin
               if (b0 == 8'h00 && b1 == 8'h86) begin
                  if (n == 4) begin
                     if ({b2, b3} != 16'h0) begin m_en = 1; m_mask = {b2, b3}; end
                     else m_en = 0;
                  end
               end else if (int'(b2) > n - 3 || int'(b2) > 252) begin
                  foreach (m_rep[k]) m_rep[k] = 0;
                  m_rsize = 1; m_int = 1; wr = 1;
               end else begin
                  m_busy = 1; m_qlen = n - 2;
                  m_req[0] = b0;
                  for (int k = 1; k < 14; k++)
                     m_req[k] = (k < n - 2) ? pkt_bytes[8*(k+2) +: 8] : 8'h00;
               end
            end
         end
         if (rep_ack && !wr) begin
            m_int = 0; m_rsize = 0;
            foreach (m_rep[k]) m_rep[k] = 0;
         end
      end
   end

   // Compare every output against the model on every clock
   always @(negedge clk) begin
      logic [111:0] eq;
      logic [79:0]  er;
      if (rst_n && !done) begin
         for (int k = 0; k < 14; k++) eq[8*k +: 8] = m_req[k];
         for (int k = 0; k < 10; k++) er[8*k +: 8] = m_rep[k];
         chk("R10 pkt_ready",  128'(pkt_ready),  128'(!m_busy));
         chk("R10 ap_hold",    128'(ap_hold),    128'(m_busy));
         chk("R6 breq_valid",  128'(breq_valid), 128'(m_busy));
         chk("R6 breq_len",    128'(breq_len),   128'(m_qlen));
         chk("R6 breq_bytes",  128'(breq_bytes), 128'(eq));
         chk("R4 ap_enable",   128'(ap_enable),  128'(m_en));
         chk("R3 ap_mask",     128'(ap_mask),    128'(m_mask));
         chk("R8 rep_int",     128'(rep_int),    128'(m_int));
         chk("R7 rep_size",    128'(rep_size),   128'(m_rsize));
         chk("R7 rep_bytes",   128'(rep_bytes),  128'(er));
      end
   end

   // ---------------- stimulus helpers ----------------
   logic [7:0] pb [16];

   function automatic logic [127:0] packb();
      logic [127:0] v;
      for (int k = 0; k < 16; k++) v[8*k +: 8] = pb[k];
      return v;
   endfunction

   task automatic set4(input logic [7:0] a, b, c, d);
      pb[0] = a; pb[1] = b; pb[2] = c; pb[3] = d;
   endtask

   task automatic send(input bit kind, input int cnt);
      pkt_kind  = kind;
      pkt_count = 5'(cnt);
      pkt_bytes = packb();
      pkt_valid = 1'b1;
      @(negedge clk);
      pkt_valid = 1'b0;
   endtask

   task automatic respond(input int len, input bit ack, input int delay);
      repeat (delay) @(negedge clk);
      bus_rsp_len = 4'(len);
      for (int k = 0; k < 8; k++) bus_rsp_bytes[8*k +: 8] = 8'(8'h40 + k*3 + len);
      bus_rsp_valid = 1'b1;
      rep_ack = ack;
      @(negedge clk);
      bus_rsp_valid = 1'b0;
      rep_ack = 1'b0;
   endtask

   task automatic ack_pulse();
      rep_ack = 1'b1;
      @(negedge clk);
      rep_ack = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WATCHDOG && !done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- directed and random sequence ----------------
   initial begin
      rst_n = 0; bus_present = 1; pkt_valid = 0; pkt_kind = 0; pkt_count = 0;
      pkt_bytes = '0; bus_rsp_valid = 0; bus_rsp_len = 0; bus_rsp_bytes = '0; rep_ack = 0;
      for (int k = 0; k < 16; k++) pb[k] = 8'hee;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      chk("R11 pkt_ready", 128'(pkt_ready), 128'(1));
      chk("R11 ap_enable", 128'(ap_enable), 128'(0));
      chk("R11 ap_mask",   128'(ap_mask),   128'(0));
      chk("R11 rep_int",   128'(rep_int),   128'(0));
      chk("R11 rep_size",  128'(rep_size),  128'(0));
      chk("R11 breq_valid",128'(breq_valid),128'(0));

      // R1 too short and too long
      set4(8'h2c, 8'h11, 8'h00, 8'h00);
      send(0, 1);
      chk("R1 short rep_size", 128'(rep_size), 128'(0));
      chk("R1 short breq_valid", 128'(breq_valid), 128'(0));
      send(0, 17);
      chk("R1 long rep_int", 128'(rep_int), 128'(0));
      chk("R1 long breq_valid", 128'(breq_valid), 128'(0));

      // R3 / R4 autopoll form
      set4(8'h00, 8'h86, 8'h12, 8'h34);
      send(0, 4);
      chk("R3 mask load", 128'(ap_mask), 128'(16'h1234));
      chk("R4 enable set", 128'(ap_enable), 128'(1));
      set4(8'h00, 8'h86, 8'h55, 8'h66);
      send(0, 5);
      chk("R3 wrong count ignored", 128'(ap_mask), 128'(16'h1234));
      set4(8'h00, 8'h86, 8'h00, 8'h00);
      send(0, 4);
      chk("R4 zero mask disables", 128'(ap_enable), 128'(0));
      chk("R4 zero mask keeps mask", 128'(ap_mask), 128'(16'h1234));
      set4(8'h00, 8'h86, 8'h00, 8'hff);
      send(0, 4);

      // R2 bus absent
      bus_present = 0;
      send(1, 0);
      chk("R2 polloff absent", 128'(ap_enable), 128'(1));
      set4(8'h2c, 8'h11, 8'h01, 8'h77);
      send(0, 4);
      chk("R2 packet absent breq", 128'(breq_valid), 128'(0));
      chk("R2 packet absent reply", 128'(rep_size), 128'(0));
      bus_present = 1;

      // R9 poll-off
      send(1, 1);
      chk("R9 polloff with args", 128'(ap_enable), 128'(1));
      send(1, 0);
      chk("R9 polloff", 128'(ap_enable), 128'(0));

      // R5 declared length error
      set4(8'h2c, 8'h11, 8'h04, 8'h01);
      send(0, 6);
      chk("R5 err size", 128'(rep_size), 128'(1));
      chk("R5 err bytes", 128'(rep_bytes), 128'(0));
      chk("R5 err int", 128'(rep_int), 128'(1));
      ack_pulse();
      chk("R8 ack clears int", 128'(rep_int), 128'(0));
      chk("R8 ack clears size", 128'(rep_size), 128'(0));
      send(0, 2);
      chk("R5 count two", 128'(rep_size), 128'(1));
      ack_pulse();

      // R6 / R10 / R7 bus request and reply
      pb[0] = 8'h2c; pb[1] = 8'h11; pb[2] = 8'h03;
      pb[3] = 8'ha1; pb[4] = 8'ha2; pb[5] = 8'ha3; pb[6] = 8'ha4;
      send(0, 7);
      chk("R6 breq_len", 128'(breq_len), 128'(5));
      chk("R6 breq_bytes", 128'(breq_bytes), 128'(112'h000000000000000000a4a3a2a12c));
      chk("R10 ready low", 128'(pkt_ready), 128'(0));
      chk("R10 hold high", 128'(ap_hold), 128'(1));
      set4(8'h00, 8'h86, 8'hab, 8'hcd);
      send(0, 4);
      chk("R10 busy offer ignored", 128'(ap_mask), 128'(16'h00ff));
      respond(3, 0, 1);
      chk("R7 reply size", 128'(rep_size), 128'(5));
      chk("R7 reply bytes", 128'(rep_bytes), 128'(80'h00000000004946430301));
      chk("R8 int on reply", 128'(rep_int), 128'(1));
      chk("R6 released", 128'(breq_valid), 128'(0));

      // R7 failure responses
      pb[0] = 8'h3c; pb[2] = 8'h00;
      send(0, 3);
      chk("R6 single byte req", 128'(breq_len), 128'(1));
      respond(0, 0, 0);
      chk("R7 empty reply", 128'(rep_size), 128'(1));
      send(0, 3);
      respond(12, 0, 2);
      chk("R7 oversize reply", 128'(rep_size), 128'(1));
      send(0, 3);
      respond(8, 0, 0);
      chk("R7 full reply", 128'(rep_size), 128'(10));

      // R8 collision: pickup in same cycle as reply write
      send(0, 3);
      respond(2, 1, 0);
      chk("R8 write wins int", 128'(rep_int), 128'(1));
      chk("R8 write wins size", 128'(rep_size), 128'(4));
      pb[2] = 8'h09;
      rep_ack = 1'b1;
      send(0, 5);
      rep_ack = 1'b0;
      chk("R8 err write wins", 128'(rep_size), 128'(1));
      chk("R8 err write int", 128'(rep_int), 128'(1));

      // Random traffic against the model
      for (int it = 0; it < 400; it++) begin
         int cnt;
         cnt = int'($urandom_range(0, 17));
         for (int k = 0; k < 16; k++) pb[k] = 8'($urandom);
         if ($urandom_range(0, 3) == 0) begin pb[0] = 8'h00; pb[1] = 8'h86; end
         if ($urandom_range(0, 4) != 0) pb[2] = 8'($urandom_range(0, 16));
         if ($urandom_range(0, 5) == 0) begin pb[2] = 8'h00; pb[3] = 8'h00; end
         bus_present = ($urandom_range(0, 9) != 0);
         rep_ack = ($urandom_range(0, 5) == 0);
         send($urandom_range(0, 7) == 0, cnt);
         rep_ack = 1'b0;
         if (m_busy)
            respond(int'($urandom_range(0, 11)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 3)));
         else if ($urandom_range(0, 3) == 0)
            ack_pulse();
      end
      bus_present = 1;
      repeat (2) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule